// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic use an external asynchronous static RAM of 256K words by 8 bits. A host starts one access at a time over a request/acknowledge handshake. It supplies an 18-bit address, a read/write select and, for writes, a data byte. The controller then drives the memory's address lines, its two chip enables (one active low, one active high), its active-low write and output enables, and a split data path: outgoing data, incoming data and an enable for the pad's tri-state driver.

All memory timing comes from counting system clock cycles. Each minimum is given in nanoseconds together with the clock period. Every count is the ceiling of the nanosecond value divided by the period, plus one safety cycle. The clock is 5 ns, so by default a read lasts 12 cycles and the write pulse lasts 9 cycles. The bus release allowance is 5 cycles, and the write recovery is padded so that the whole write cycle meets its minimum.

A read holds the memory selected with output enable low, and captures the data on the last counted cycle. A write never lowers output enable. It first waits out a turnaround in which nobody drives the bus. It then pulses write enable low while its own driver presents the data, and keeps the driver on for a recovery cycle after write enable rises.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset and whenever idle: memCeN=1, memCe2=0, memWeN=1, memOeN=1, memDqOe=0 and ack=0.
- R2: A read request accepted in idle holds memCeN=0, memCe2=1, memWeN=1 and memOeN=0 for exactly RD_CYC cycles (default 12, from 55 ns), with memAddr equal to the requested address.
- R3: rdata takes the value present on memDqIn during the final read cycle and holds it from the acknowledge cycle onward.
- R4: A write request begins with TURN_CYC cycles (default 5, from 20 ns) in which the memory is selected, memWeN=1, memOeN=1 and memDqOe=0.
- R5: memWeN is then low for exactly WP_CYC cycles (default 9, from 40 ns), with memDqOe=1, memDqOut equal to the write data and memOeN=1 throughout.
- R6: After memWeN rises, the driver stays on with the same data for REC_CYC cycles. By default that is 1 cycle, which makes the write total at least 12 cycles (55 ns). The memory is then deselected and the driver turned off.
- R7: ack is a one-cycle pulse in the cycle after the last access cycle. Counted in clock cycles from the accepting edge, ack appears 13 cycles after a read request and 16 cycles after a write request.
- R8: A request raised while an access is in progress is ignored and not queued. No further access and no further ack follow.
- R9: memAddr, memCeN and memCe2 do not change while the memory is selected.
- R10: The controller's driver never turns on while the memory drives or in the 4 cycles (20 ns) after the memory stops driving. It is also never on while memOeN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled only in idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| memAddr | output | 18 | Memory address lines |
| memCeN | output | 1 | Active-low chip enable |
| memCe2 | output | 1 | Active-high chip enable |
| memWeN | output | 1 | Active-low write enable |
| memOeN | output | 1 | Active-low output enable |
| memDqOut | output | 8 | Data toward the memory |
| memDqIn | input | 8 | Data from the memory |
| memDqOe | output | 1 | Enable for the controller's data driver |

## Verification
The assertions assume that the host raises req only for a single cycle in idle, or as a deliberate single-cycle poke while busy. They also assume that it drops req before the acknowledge, so that no second access is launched on the ack cycle. The stimulus follows this rule: it raises req at a falling edge, clears it one cycle later and never holds it across the completion. The memory model in the bench returns inverted data until the read has lasted its full count, so an early capture shows up as a data mismatch. It also reports write pulses or bus turnarounds that are shorter than the configured minimums.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  // Strobes from control to datapath; pin fields are registered, load/capture are single-cycle.
  typedef struct packed {
    logic sel;
    logic weLow;
    logic oeLow;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;

  // Ceiling of ns over period, plus one safety cycle.
  function automatic int nsToCyc(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs + 1;
  endfunction

  // Recovery padding so turnaround + pulse + recovery covers the full write cycle.
  function automatic int recCycles(input int wcCyc, input int turnCyc, input int wpCyc);
    int rem;
    rem = wcCyc - turnCyc - wpCyc;
    return (rem > 1) ? rem : 1;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC   = 12,
  parameter int TURN_CYC = 5,
  parameter int WP_CYC   = 9,
  parameter int REC_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    wr,
  output strobe_t stb,
  output logic    ack
);

  localparam int MAX_A = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
  localparam int MAX_B = (WP_CYC > REC_CYC) ? WP_CYC : REC_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_TURN, S_WPULSE, S_RECOV} state_t;

  state_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext, lim;
  logic last;
  logic selQ, weLowQ, oeLowQ, driveQ;

  always_comb begin
    case (state)
      S_READ:   lim = CNT_W'(RD_CYC - 1);
      S_TURN:   lim = CNT_W'(TURN_CYC - 1);
      S_WPULSE: lim = CNT_W'(WP_CYC - 1);
      S_RECOV:  lim = CNT_W'(REC_CYC - 1);
      default:  lim = '0;
    endcase
  end

  assign last = (cnt == lim);

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:   if (req) stateNext = wr ? S_TURN : S_READ;
      S_READ:   if (last) stateNext = S_IDLE;
      S_TURN:   if (last) stateNext = S_WPULSE;
      S_WPULSE: if (last) stateNext = S_RECOV;
      S_RECOV:  if (last) stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
    if (state == S_IDLE || stateNext != state) cntNext = '0;
    else                                        cntNext = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      selQ   <= 1'b0;
      weLowQ <= 1'b0;
      oeLowQ <= 1'b0;
      driveQ <= 1'b0;
      ack    <= 1'b0;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      selQ   <= (stateNext != S_IDLE);
      weLowQ <= (stateNext == S_WPULSE);
      oeLowQ <= (stateNext == S_READ);
      driveQ <= (stateNext == S_WPULSE) || (stateNext == S_RECOV);
      ack    <= (state != S_IDLE) && (stateNext == S_IDLE);
    end
  end

  always_comb begin
    stb.sel     = selQ;
    stb.weLow   = weLowQ;
    stb.oeLow   = oeLowQ;
    stb.drive   = driveQ;
    stb.load    = (state == S_IDLE) && req;
    stb.capture = (state == S_READ) && last;
  end

  // R7: completion pulse lasts one cycle and coincides with deselection
  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rstN) ack |=> !ack);
  a_r7_ack_deselected: assert property (@(posedge clk) disable iff (!rstN) ack |-> !stb.sel);
  // R6: driver still on in the cycle after write enable rises
  a_r6_hold_after_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.weLow) |-> stb.drive);
  // R8: no load while selected
  a_r8_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sel && !ack) |-> !stb.load || ack);

endmodule

// File: rtl/sram_ctl_dp.sv
`timescale 1ns/1ps
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdata  <= '0;
    end else begin
      if (stb.load) begin
        addrQ  <= addr;
        wdataQ <= wdata;
      end
      if (stb.capture) rdata <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memCeN   = ~stb.sel;
  assign memCe2   = stb.sel;
  assign memWeN   = ~stb.weLow;
  assign memOeN   = ~stb.oeLow;
  assign memDqOut = wdataQ;
  assign memDqOe  = stb.drive;

  // R5: output enable high and driver on for the whole write pulse
  a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && memDqOe));
  // R10: never drive while the memory is allowed to drive
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDqOe);
  // R9: address steady while the memory stays selected
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));
  // R5: write data steady during the pulse
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memDqOut));

endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int T_RD_NS   = 55,
  parameter int T_WP_NS   = 40,
  parameter int T_WC_NS   = 55,
  parameter int T_REL_NS  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  localparam int RD_CYC   = nsToCyc(T_RD_NS, CLK_NS);
  localparam int WP_CYC   = nsToCyc(T_WP_NS, CLK_NS);
  localparam int WC_CYC   = nsToCyc(T_WC_NS, CLK_NS);
  localparam int TURN_CYC = nsToCyc(T_REL_NS, CLK_NS);
  localparam int REC_CYC  = recCycles(WC_CYC, TURN_CYC, WP_CYC);

  strobe_t stb;

  sram_ctl_fsm #(
    .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .stb(stb), .ack(ack)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wdata(wdata),
    .memDqIn(memDqIn), .rdata(rdata), .memAddr(memAddr), .memCeN(memCeN),
    .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe)
  );

endmodule

// File: tb/sram_async_ctl_tb.sv
`timescale 1ns/1ps
module sram_async_ctl_tb_top;

  localparam int RD_NEED   = 12;  // read cycles
  localparam int WP_NEED   = 9;   // write pulse cycles
  localparam int REL_NEED  = 4;   // idle cycles after memory release
  localparam int RD_LAT    = 13;  // R7 read latency in cycles
  localparam int WR_LAT    = 16;  // R7 write latency in cycles

  logic clk = 1'b0, rstN = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ack;
  logic [7:0] rdata, memDqOut, memDqIn;
  logic [17:0] memAddr;
  logic memCeN, memCe2, memWeN, memOeN, memDqOe;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sram_async_ctl dut_i (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .memAddr(memAddr), .memCeN(memCeN), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut), .memDqIn(memDqIn),
    .memDqOe(memDqOe)
  );

  // Memory model: 1024 words aliased on addr[9:0]
  logic [7:0] modelMem [0:1023];
  logic [7:0] refMem   [0:1023];
  int rdCnt = 0, weCnt = 0, relCnt = 100;
  logic [17:0] rdAddr = '0;
  logic [7:0] latchData = '0;
  logic [9:0] latchIdx = '0;
  logic prevWe = 1'b0, prevOe = 1'b0;
  logic [17:0] hostAddr = '0;
  int addrBad = 0, modelBad = 0, wePulses = 0;

  wire rdCond = !memCeN && memCe2 && memWeN && !memOeN;
  wire weCond = !memCeN && memCe2 && !memWeN;

  // Inverted data until the read has lasted its full count (R3)
  assign memDqIn = rdCond ? ((rdCnt >= RD_NEED - 1) ? modelMem[memAddr[9:0]]
                                                   : ~modelMem[memAddr[9:0]]) : 8'h00;

  function automatic logic [7:0] initByte(input int i);
    return 8'(i) ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      if (!memCeN && memAddr != hostAddr) addrBad <= addrBad + 1;
      if (rdCond && (rdCnt == 0 || memAddr == rdAddr)) begin
        rdCnt <= rdCnt + 1; rdAddr <= memAddr;
      end else rdCnt <= 0;
      if (rdCond) relCnt <= 0; else if (relCnt < 100) relCnt <= relCnt + 1;
      if (memDqOe && !prevOe && relCnt < REL_NEED) begin
        modelBad <= modelBad + 1;
        $display("FAIL R10 turnaround idle=%0d expected>=%0d", relCnt, REL_NEED);
      end
      if (weCond) begin
        weCnt <= weCnt + 1; latchData <= memDqOut; latchIdx <= memAddr[9:0];
        if (!memDqOe || !memOeN) begin
          modelBad <= modelBad + 1;
          $display("FAIL R5 pulse dqOe=%0b oeN=%0b expected 1/1", memDqOe, memOeN);
        end
      end else if (prevWe) begin
        wePulses <= wePulses + 1;
        if (weCnt < WP_NEED) begin
          modelBad <= modelBad + 1;
          $display("FAIL R5 pulse width=%0d expected>=%0d", weCnt, WP_NEED);
        end
        modelMem[latchIdx] <= latchData;
        weCnt <= 0;
      end
      prevWe <= weCond;
      prevOe <= memDqOe;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit isWr, input logic [17:0] a, input logic [7:0] d, input bit poke);
    int n;
    logic [7:0] expRd;
    int badStart;
    badStart = addrBad;
    expRd = refMem[a[9:0]];
    @(negedge clk);
    hostAddr = a;
    req = 1'b1; wr = isWr; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; n = 1;
    // R2 / R4: first selected cycle
    check(!memCeN && memCe2 && memWeN && (memOeN == isWr) && !memDqOe,
          isWr ? "R4 turnaround pins" : "R2 read pins",
          {memCeN, memCe2, memWeN, memOeN, memDqOe}, {1'b0, 1'b1, 1'b1, isWr, 1'b0});
    while (!ack && n < 100) begin
      @(negedge clk);
      n++;
      if (poke && n == 3) begin req = 1'b1; wr = ~isWr; addr = ~a; end
      if (poke && n == 4) req = 1'b0;
      if (isWr && n == 7)
        check(!memWeN && memDqOe && memDqOut == d, "R5 pulse data", memDqOut, d);
      if (isWr && n == 15)
        check(memWeN && memDqOe && memDqOut == d, "R6 recovery hold", {memWeN, memDqOe}, 2'b11);
    end
    check(n == (isWr ? WR_LAT : RD_LAT), "R7 latency", n, isWr ? WR_LAT : RD_LAT);
    check(memCeN && !memCe2 && !memDqOe, "R6 release", {memCeN, memCe2, memDqOe}, 3'b100);
    if (!isWr) check(rdata == expRd, "R3 read data", rdata, expRd);
    else refMem[a[9:0]] = d;
    check(addrBad == badStart, "R9 address stable", addrBad - badStart, 0);
    @(negedge clk);
    check(!ack, "R7 ack single cycle", ack, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      check(memCeN && !ack, "R8 busy request ignored", {memCeN, ack}, 2'b10);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      modelMem[i] = initByte(i);
      refMem[i]   = initByte(i);
    end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(memCeN && !memCe2 && memWeN && memOeN && !memDqOe && !ack, "R1 reset pins",
          {memCeN, memCe2, memWeN, memOeN, memDqOe, ack}, 6'b101100);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(memCeN && !memCe2 && memWeN && memOeN && !memDqOe && !ack, "R1 idle pins",
          {memCeN, memCe2, memWeN, memOeN, memDqOe, ack}, 6'b101100);
    // Directed corners
    access(1'b0, 18'h00000, 8'h00, 1'b0);
    access(1'b1, 18'h00000, 8'hFF, 1'b0);   // R10: read then write back to back
    access(1'b0, 18'h00000, 8'h00, 1'b0);
    access(1'b1, 18'h3FFFF, 8'h00, 1'b0);
    access(1'b0, 18'h3FFFF, 8'h00, 1'b0);
    access(1'b0, 18'h12345, 8'h00, 1'b1);   // R8 poke during read
    access(1'b1, 18'h2A5A5, 8'hA5, 1'b1);   // R8 poke during write
    access(1'b0, 18'h2A5A5, 8'h00, 1'b0);
    // Random mix
    for (int k = 0; k < 60; k++) begin
      logic [17:0] ra;
      ra = 18'($urandom);
      if (k % 3 == 0) ra[9:0] = 10'($urandom % 8);   // reuse a few words
      access(1'($urandom), ra, 8'($urandom), (k % 11) == 5);
    end
    check(modelBad == 0, "R10 model timing violations", modelBad, 0);
    check(wePulses > 0, "R5 pulses observed", wePulses, 1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule